// File: doc/BRIEF.md
# Delay Sweep Eye Window Finder

This block runs one delay sweep during memory interface calibration. A start pulse captures a base delay. The block then walks a sweep index from zero upward in fixed steps. At each step it drives `base + index` onto the delay output and pulses an update strobe. It then raises a test request and holds it until an external tester answers with a done pulse and a pass flag.

While it sweeps, the block keeps two runs of passing steps: the run in progress and the longest one seen so far. A failure clears the run in progress. The block also stops the sweep early once the steps still to come cannot produce a longer run. At the end it computes a left edge, a right edge, a centre correction that never goes negative and a signed margin. It then drives the base delay back onto the output with one more strobe, and pulses done. The results stay on the outputs until the next sweep starts.

Top module: `delay_eye_finder`

## Requirements
- R1: While reset is asserted, and after it is released, `busy`, `done`, `test_req` and `delay_upd` are low and `delay_out` is 0.
- R2: A start pulse while idle captures `base_delay`. The sweep index then takes the values 0, DELTA, 2·DELTA and so on, up to the largest value not above MAX_DELAY−base. Each step drives `base + index` on `delay_out`, with `delay_upd` high for exactly one cycle in the first cycle of that value.
- R3: `test_req` rises in the same cycle as each step's strobe. It stays high, with `delay_out` unchanged, until the cycle in which `test_done` is sampled high. The result is taken from `test_pass` in that cycle, and exactly one test is requested per step.
- R4: The best run is replaced only when the run in progress becomes strictly longer. Run length is end index − begin index + 1, counted in index units. When two runs have the same length, the earlier one is kept.
- R5: A failing step discards the run in progress, so the next passing step starts a new run at its own index.
- R6: On a failing step at index i, the sweep stops after that step if (best length − 1) > (MAX_DELAY − base − i). With no passing step yet, the left side of that comparison is −1.
- R7: `left_edge` is the negated begin index of the best run and `right_edge` is its end index. Both are 0 when nothing passed.
- R8: `centre` is (left_edge − right_edge)/2 in signed arithmetic, truncated toward zero. A negative value is replaced by 0.
- R9: `margin` is −1 when no step passed, and otherwise left_edge − centre. `pass_ok` is high exactly when `margin` ≥ 0.
- R10: When the sweep ends, `delay_out` returns to the captured base with one more one-cycle `delay_upd`. `done` is high for one cycle, together with that strobe, and the results are valid in that cycle.
- R11: A start pulse while busy is ignored. After done, all result outputs hold their values until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a sweep (only while idle) |
| base_delay | input | UW | Base delay captured at start |
| test_req | output | 1 | Request for a test at the current setting |
| test_done | input | 1 | Tester has finished the current test |
| test_pass | input | 1 | Tester result, read when test_done is high |
| delay_out | output | UW | Delay setting applied to the I/O |
| delay_upd | output | 1 | One-cycle strobe after each setting change |
| busy | output | 1 | Sweep in progress |
| done | output | 1 | One-cycle end-of-sweep pulse |
| left_edge | output | SW | Negated begin index of the best run (signed) |
| right_edge | output | SW | End index of the best run (signed) |
| centre | output | SW | Clamped centre correction (signed) |
| margin | output | SW | Signed margin, −1 when nothing passed |
| pass_ok | output | 1 | High when margin is non-negative |

## Verification
The hardest behaviour to reach from the ports is the early stop. It needs a best run already recorded and a failure at an index where the range left is just one short of that run. The tie rule is a close second, since it needs two runs of exactly the same length. The stimulus drives these cases with a pass map indexed by the applied delay, and a reference model computes the exact sequence of delays expected for each map. One sweep also receives a second start pulse with a different base in the middle of the run, to show that the captured base is not disturbed. The tester's reply latency varies with the delay, so the hold time of each request differs from step to step.

// File: rtl/eye_pkg.sv
package eye_pkg;
  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_APPLY   = 3'd1,
    ST_WAIT    = 3'd2,
    ST_RESTORE = 3'd3,
    ST_FIN     = 3'd4
  } eye_state_t;
endpackage

// File: rtl/eye_seq.sv
module eye_seq
  import eye_pkg::*;
#(
  parameter int MAX_DELAY = 31,
  parameter int DELTA     = 1,
  parameter int UW        = 5,
  parameter int SW        = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [UW-1:0]        base_delay,
  input  logic                 test_done,
  input  logic                 test_pass,
  input  logic signed [SW-1:0] best_w,
  output logic signed [SW-1:0] idx,
  output logic [UW-1:0]        delay_out,
  output logic                 delay_upd,
  output logic                 test_req,
  output logic                 busy,
  output logic                 done,
  output logic                 clear,
  output logic                 eval_en,
  output logic                 load
);
  localparam logic signed [SW-1:0] MAXS = SW'(MAX_DELAY);
  localparam logic signed [SW-1:0] STEP = SW'(DELTA);
  localparam logic signed [SW-1:0] ONE  = SW'(1);

  eye_state_t            state_q, state_d;
  logic signed [SW-1:0]  idx_q, idx_d;
  logic [UW-1:0]         base_q, base_d;
  logic [UW-1:0]         dly_q, dly_d;
  logic                  upd_q, upd_d;
  logic signed [SW-1:0]  base_s, span_s, idx_nx, rem_s;
  logic                  early_stop, range_end;

  assign base_s     = signed'({{(SW-UW){1'b0}}, base_q});
  assign span_s     = MAXS - base_s;
  assign idx_nx     = idx_q + STEP;
  assign rem_s      = span_s - idx_q;
  assign early_stop = !test_pass && ((best_w - ONE) > rem_s);
  assign range_end  = idx_nx > span_s;

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    base_d  = base_q;
    dly_d   = dly_q;
    upd_d   = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (start) begin
          base_d  = base_delay;
          idx_d   = '0;
          state_d = ST_APPLY;
        end
      end
      ST_APPLY: begin
        dly_d   = UW'(base_s + idx_q);
        upd_d   = 1'b1;
        state_d = ST_WAIT;
      end
      ST_WAIT: begin
        if (test_done) begin
          if (early_stop || range_end) begin
            state_d = ST_RESTORE;
          end else begin
            idx_d   = idx_nx;
            state_d = ST_APPLY;
          end
        end
      end
      ST_RESTORE: begin
        dly_d   = base_q;
        upd_d   = 1'b1;
        state_d = ST_FIN;
      end
      ST_FIN:  state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      base_q  <= '0;
      dly_q   <= '0;
      upd_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      base_q  <= base_d;
      dly_q   <= dly_d;
      upd_q   <= upd_d;
    end
  end

  assign idx       = idx_q;
  assign delay_out = dly_q;
  assign delay_upd = upd_q;
  assign test_req  = (state_q == ST_WAIT);
  assign busy      = (state_q != ST_IDLE);
  assign done      = (state_q == ST_FIN);
  assign clear     = (state_q == ST_IDLE) && start;
  assign eval_en   = (state_q == ST_WAIT) && test_done;
  assign load      = (state_q == ST_RESTORE);
endmodule

// File: rtl/eye_track.sv
module eye_track #(
  parameter int MAX_DELAY = 31,
  parameter int SW        = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clear,
  input  logic                 eval_en,
  input  logic                 pass,
  input  logic signed [SW-1:0] idx,
  output logic signed [SW-1:0] best_w,
  output logic signed [SW-1:0] best_b,
  output logic signed [SW-1:0] best_e
);
  localparam logic signed [SW-1:0] SENT = SW'(MAX_DELAY + 1);
  localparam logic signed [SW-1:0] ONE  = SW'(1);

  logic signed [SW-1:0] cb_q, cb_d, ce_q, ce_d;
  logic signed [SW-1:0] bw_q, bw_d, bb_q, bb_d, be_q, be_d;
  logic signed [SW-1:0] cb_cand, run_len;

  assign cb_cand = (cb_q == SENT) ? idx : cb_q;
  assign run_len = idx - cb_cand + ONE;

  always_comb begin
    cb_d = cb_q;
    ce_d = ce_q;
    bw_d = bw_q;
    bb_d = bb_q;
    be_d = be_q;
    if (clear) begin
      cb_d = SENT;
      ce_d = SENT;
      bw_d = '0;
      bb_d = '0;
      be_d = '0;
    end else if (eval_en) begin
      if (pass) begin
        ce_d = idx;
        cb_d = cb_cand;
        if (run_len > bw_q) begin
          bw_d = run_len;
          bb_d = cb_cand;
          be_d = idx;
        end
      end else begin
        cb_d = SENT;
        ce_d = SENT;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cb_q <= SENT;
      ce_q <= SENT;
      bw_q <= '0;
      bb_q <= '0;
      be_q <= '0;
    end else begin
      cb_q <= cb_d;
      ce_q <= ce_d;
      bw_q <= bw_d;
      bb_q <= bb_d;
      be_q <= be_d;
    end
  end

  assign best_w = bw_q;
  assign best_b = bb_q;
  assign best_e = be_q;
endmodule

// File: rtl/eye_result.sv
module eye_result #(
  parameter int SW = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 load,
  input  logic signed [SW-1:0] best_w,
  input  logic signed [SW-1:0] best_b,
  input  logic signed [SW-1:0] best_e,
  output logic signed [SW-1:0] left_edge,
  output logic signed [SW-1:0] right_edge,
  output logic signed [SW-1:0] centre,
  output logic signed [SW-1:0] margin,
  output logic                 pass_ok
);
  localparam logic signed [SW-1:0] ZERO = '0;
  localparam logic signed [SW-1:0] NEG1 = '1;

  logic signed [SW-1:0] left_d, diff_d, biased_d, half_d, cen_d, mar_d;
  logic signed [SW-1:0] left_q, right_q, cen_q, mar_q;
  logic                 ok_q;

  assign left_d   = ZERO - best_b;
  assign diff_d   = left_d - best_e;
  assign biased_d = diff_d + {{(SW-1){1'b0}}, diff_d[SW-1]};
  assign half_d   = biased_d >>> 1;
  assign cen_d    = half_d[SW-1] ? ZERO : half_d;
  assign mar_d    = (best_w == ZERO) ? NEG1 : (left_d - cen_d);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left_q  <= '0;
      right_q <= '0;
      cen_q   <= '0;
      mar_q   <= '0;
      ok_q    <= 1'b0;
    end else if (load) begin
      left_q  <= left_d;
      right_q <= best_e;
      cen_q   <= cen_d;
      mar_q   <= mar_d;
      ok_q    <= !mar_d[SW-1];
    end
  end

  assign left_edge  = left_q;
  assign right_edge = right_q;
  assign centre     = cen_q;
  assign margin     = mar_q;
  assign pass_ok    = ok_q;
endmodule

// File: rtl/delay_eye_finder.sv
module delay_eye_finder #(
  parameter int MAX_DELAY = 31,
  parameter int DELTA     = 1,
  parameter int UW        = $clog2(MAX_DELAY + 1),
  parameter int SW        = $clog2(MAX_DELAY + 2) + 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [UW-1:0]        base_delay,
  output logic                 test_req,
  input  logic                 test_done,
  input  logic                 test_pass,
  output logic [UW-1:0]        delay_out,
  output logic                 delay_upd,
  output logic                 busy,
  output logic                 done,
  output logic signed [SW-1:0] left_edge,
  output logic signed [SW-1:0] right_edge,
  output logic signed [SW-1:0] centre,
  output logic signed [SW-1:0] margin,
  output logic                 pass_ok
);
  logic signed [SW-1:0] idx, best_w, best_b, best_e;
  logic                 clear, eval_en, load;

  eye_seq #(.MAX_DELAY(MAX_DELAY), .DELTA(DELTA), .UW(UW), .SW(SW)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .base_delay(base_delay),
    .test_done(test_done), .test_pass(test_pass), .best_w(best_w),
    .idx(idx), .delay_out(delay_out), .delay_upd(delay_upd),
    .test_req(test_req), .busy(busy), .done(done),
    .clear(clear), .eval_en(eval_en), .load(load)
  );

  eye_track #(.MAX_DELAY(MAX_DELAY), .SW(SW)) u_track (
    .clk(clk), .rst_n(rst_n), .clear(clear), .eval_en(eval_en),
    .pass(test_pass), .idx(idx),
    .best_w(best_w), .best_b(best_b), .best_e(best_e)
  );

  eye_result #(.SW(SW)) u_result (
    .clk(clk), .rst_n(rst_n), .load(load),
    .best_w(best_w), .best_b(best_b), .best_e(best_e),
    .left_edge(left_edge), .right_edge(right_edge),
    .centre(centre), .margin(margin), .pass_ok(pass_ok)
  );
endmodule

// File: rtl/eye_finder_chk.sv
module eye_finder_chk #(
  parameter int MAX_DELAY = 31,
  parameter int UW        = $clog2(MAX_DELAY + 1),
  parameter int SW        = $clog2(MAX_DELAY + 2) + 2
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 test_req,
  input logic                 test_done,
  input logic [UW-1:0]        delay_out,
  input logic                 delay_upd,
  input logic                 busy,
  input logic                 done,
  input logic signed [SW-1:0] left_edge,
  input logic signed [SW-1:0] centre
);
  p_upd_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    delay_upd |=> !delay_upd);

  p_setting_held_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (test_req && !test_done) |=> (test_req && $stable(delay_out)));

  p_left_nonpos_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (left_edge <= 0));

  p_centre_nonneg_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !centre[SW-1]);

  p_restore_strobe_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (delay_upd && !test_req));

  p_done_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy));

  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!test_req && !delay_upd && !done));
endmodule

bind delay_eye_finder eye_finder_chk #(.MAX_DELAY(MAX_DELAY), .UW(UW), .SW(SW)) u_chk (
  .clk(clk), .rst_n(rst_n), .test_req(test_req), .test_done(test_done),
  .delay_out(delay_out), .delay_upd(delay_upd), .busy(busy), .done(done),
  .left_edge(left_edge), .centre(centre)
);

// File: tb/delay_eye_finder_bench.sv
module delay_eye_finder_bench;
  localparam int MAXD = 20;
  localparam int STEP = 2;
  localparam int UW   = $clog2(MAXD + 1);
  localparam int SW   = $clog2(MAXD + 2) + 2;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, start, test_done, test_pass;
  logic [UW-1:0] base_delay;
  logic test_req, delay_upd, busy, done, pass_ok;
  logic [UW-1:0] delay_out;
  logic signed [SW-1:0] left_edge, right_edge, centre, margin;

  delay_eye_finder #(.MAX_DELAY(MAXD), .DELTA(STEP)) u_delay_eye_finder (
    .clk(clk), .rst_n(rst_n), .start(start), .base_delay(base_delay),
    .test_req(test_req), .test_done(test_done), .test_pass(test_pass),
    .delay_out(delay_out), .delay_upd(delay_upd), .busy(busy), .done(done),
    .left_edge(left_edge), .right_edge(right_edge), .centre(centre),
    .margin(margin), .pass_ok(pass_ok)
  );

  int n_chk = 0;
  int n_bad = 0;
  int tests = 0;
  int exp_q[$];
  logic [63:0] pass_map = '0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  // Every-clock comparison of applied settings against the model queue (R2, R10)
  always @(negedge clk) begin
    if (rst_n && delay_upd) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R2", "unexpected strobe", int'(delay_out), -1);
      end else begin
        automatic int e = exp_q.pop_front();
        check(int'(delay_out) == e, "R2", "applied delay", int'(delay_out), e);
      end
    end
  end

  // Tester: variable latency, result from the pass map (R3)
  initial begin
    test_done = 1'b0;
    test_pass = 1'b0;
    forever begin
      @(negedge clk);
      test_done = 1'b0;
      if (test_req) begin
        automatic int lat = int'(delay_out) % 3;
        repeat (lat) @(negedge clk);
        test_pass = pass_map[delay_out];
        test_done = 1'b1;
        tests++;
      end
    end
  end

  task automatic run_case(input int base, input logic [63:0] map,
                          input string rq, input bit poke);
    int s, cb, ce, bw, bb, be, nt, lft, rgt, cen, mar;
    logic signed [SW-1:0] h_l, h_r, h_c, h_m;
    logic h_p;
    s = MAXD + 1; cb = s; ce = s; bw = 0; bb = 0; be = 0; nt = 0;
    for (int d = 0; d <= MAXD - base; d += STEP) begin
      exp_q.push_back(base + d);
      nt++;
      if (map[base + d]) begin
        ce = d;
        if (cb == s) cb = d;
        if (ce - cb + 1 > bw) begin bw = ce - cb + 1; bb = cb; be = ce; end
      end else begin
        cb = s; ce = s;
        if (bw - 1 > MAXD - base - d) break;
      end
    end
    exp_q.push_back(base);
    lft = -bb; rgt = be;
    cen = (lft - rgt) / 2;
    if (cen < 0) cen = 0;
    mar = (bw == 0) ? -1 : lft - cen;
    pass_map = map;
    tests = 0;
    @(negedge clk);
    base_delay = UW'(base);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      repeat (5) @(negedge clk);
      base_delay = UW'(9);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    while (!done) @(negedge clk);
    check(int'(left_edge) == lft, "R7", {rq, " left edge"}, int'(left_edge), lft);
    check(int'(right_edge) == rgt, "R7", {rq, " right edge"}, int'(right_edge), rgt);
    check(int'(centre) == cen, "R8", {rq, " centre"}, int'(centre), cen);
    check(int'(margin) == mar, "R9", {rq, " margin"}, int'(margin), mar);
    check(int'(pass_ok) == int'(mar >= 0), "R9", {rq, " pass flag"}, int'(pass_ok), int'(mar >= 0));
    check(tests == nt, rq, "tests requested", tests, nt);
    check(int'(delay_out) == base, "R10", {rq, " restored delay"}, int'(delay_out), base);
    h_l = left_edge; h_r = right_edge; h_c = centre; h_m = margin; h_p = pass_ok;
    @(negedge clk);
    check(!done && !busy, "R10", {rq, " done one cycle"}, int'(done), 0);
    check(exp_q.size() == 0, "R2", {rq, " settings left over"}, exp_q.size(), 0);
    repeat (3) @(negedge clk);
    check(left_edge == h_l && right_edge == h_r && centre == h_c &&
          margin == h_m && pass_ok == h_p, "R11", {rq, " results held"},
          int'(margin), int'(h_m));
    exp_q.delete();
  endtask

  initial begin
    #400000;
    check(1'b0, "watchdog", "run did not finish", 0, 1);
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    start = 1'b0;
    base_delay = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(!busy && !done && !test_req && !delay_upd && delay_out == '0,
          "R1", "outputs under reset", int'(busy), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy && !done && !test_req && !delay_upd && delay_out == '0,
          "R1", "outputs after reset", int'(delay_out), 0);

    // R2 full sweep, everything passes
    run_case(0, 64'h1F_FFFF, "R2", 1'b0);
    // R6 no pass at all: -1 on the left of the compare, never stops early
    run_case(4, 64'h0, "R6", 1'b0);
    // R6 early stop after a single window; R11 mid-sweep start ignored
    run_case(0, 64'h7C0, "R11", 1'b1);
    // R5 second, longer window replaces first, then early stop
    run_case(0, 64'h1_FC1C, "R5", 1'b0);
    // R4 equal windows: the earlier one is kept
    run_case(0, 64'h71C, "R4", 1'b0);
    // R3 nonzero base, window at start gives non-negative margin
    run_case(3, 64'h28, "R3", 1'b0);

    finish_run();
  end
endmodule